// File: doc/BRIEF.md
# Poison Address Range Tracker

This block keeps a fixed-capacity table of memory ranges that are known to hold corrupted data. Each table entry holds a start line, a length in 64-byte lines and a 3-bit type code. A single command port accepts four operations. Query lists the entries that overlap an address window. Inject marks one line as poisoned. Clear removes one line and splits the range that held it. Record adds a range of any length and type, as reported by the media.

A command is accepted when `cmd_start` is high and the block is idle. `busy` stays high until the one-cycle `done` pulse, which carries a return code. A query streams one clipped record per cycle on the `rec_*` outputs, in ascending slot order. The record count, an overflow flag and the overflow timestamp are valid with `done`.

A new entry always takes the lowest free slot. When the table has no free slot for the upper fragment of a split, that fragment is lost. A sticky overflow flag is then set, and the `time_now` value at that moment is kept.

Top module: `poison_range_tracker`

## Requirements
- R1: A query (op 0) whose address has a nonzero value in bits [5:0] completes with code 1 (bad input). It produces no records, and its count, flags and timestamp are 0.
- R2: A query with start line S and length L (in lines) emits one `rec_valid` record for each valid entry whose start is below S+L and whose end is above S. Records come one per cycle in ascending slot order, before `done`, and `done_count` equals the number emitted.
- R3: A record's address is the clipped start line (the larger of entry start and S) shifted left by 6, with the entry type in bits [2:0]. `rec_len` is the clipped end (the smaller of entry end and S+L) minus the clipped start, in lines.
- R4: Record (op 3) stores the line of `cmd_addr`, with `cmd_len` and `cmd_type`, in the lowest free slot and returns code 0. A zero length returns code 1, and a full table returns code 3; in both cases the table is left unchanged.
- R5: Inject (op 2'd1) works on the line containing `cmd_addr`. If an entry already holds that line, it returns 0 and changes nothing, even when the table is full. Otherwise a full table returns code 3. In all other cases it adds a one-line entry of type 3'd2 in the lowest free slot.
- R6: Clear (op 2'd2) returns code 2 (bad address) when `cmd_addr`+64 exceeds `MEM_BYTES`; a clear exactly at `MEM_BYTES`-64 is accepted. A clear whose line lies in no entry returns 0 and leaves the table unchanged.
- R7: Clear removes the lowest-slot entry holding the line. It then adds a lower fragment [start, line) if the line is above the start, and then an upper fragment [line+1, end) if one remains. Each fragment takes the lowest free slot and keeps the type of the removed entry.
- R8: If no slot is free for the upper fragment, the fragment is dropped and the overflow flag is set. Every later successful query reports `done_flags` bit 1 set and `done_ts` equal to `time_now` at the first such drop, held until reset.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted start through `done`. A `cmd_start` while busy is ignored.
- R10: After reset the table is empty, no overflow is recorded, and `busy`, `done` and `rec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start an operation (taken when idle) |
| cmd_op | input | 2 | 0 query, 1 inject, 2 clear, 3 record |
| cmd_addr | input | ADDR_W | Byte address (query window start, or target line) |
| cmd_len | input | LEN_W | Length in 64-byte lines (query, record) |
| cmd_type | input | 3 | Type code for record |
| time_now | input | TS_W | Free-running time value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 0 ok, 1 bad input, 2 bad address, 3 table full |
| rec_valid | output | 1 | Query record valid this cycle |
| rec_addr | output | ADDR_W | Clipped start address with type in bits [2:0] |
| rec_len | output | LEN_W | Clipped length in lines |
| done_count | output | $clog2(DEPTH+1) | Number of query records |
| done_flags | output | 8 | Bit 1: table has overflowed |
| done_ts | output | TS_W | Time of first overflow |

## Verification
The assertions rely on a driver that raises `cmd_start` only from a quiet idle state, or deliberately while busy, where it must be ignored. They also assume `time_now` needs no relation to the clock. The bench keeps each command's fields constant from the start cycle until `done`. It holds `time_now` at a fresh value for each operation, so the expected overflow time is known without counting cycles. Windows and ranges stay inside a 64-line space, so no window end wraps the line counter.

// File: rtl/poison_tracker_pkg.sv
package poison_tracker_pkg;
  localparam int LINE_SH = 6;
  localparam logic [2:0] TYPE_INJECTED = 3'd2;

  localparam logic [1:0] OP_QUERY  = 2'd0;
  localparam logic [1:0] OP_INJECT = 2'd1;
  localparam logic [1:0] OP_CLEAR  = 2'd2;
  localparam logic [1:0] OP_RECORD = 2'd3;

  localparam logic [1:0] RC_OK        = 2'd0;
  localparam logic [1:0] RC_BAD_INPUT = 2'd1;
  localparam logic [1:0] RC_BAD_ADDR  = 2'd2;
  localparam logic [1:0] RC_FULL      = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_APPLY, ST_FRAG_LO, ST_FRAG_HI, ST_DONE
  } trk_state_e;
endpackage

// File: rtl/poison_slot_pick.sv
module poison_slot_pick #(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8
) (
  input  logic [DEPTH-1:0] used,
  output logic [IDX_W-1:0] free_idx,
  output logic             full
);
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!used[i]) free_idx = IDX_W'(i);
    end
    full = &used;
  end
endmodule

// File: rtl/poison_range_eval.sv
module poison_range_eval #(
  parameter int LA_W  = 26,
  parameter int LEN_W = 16
) (
  input  logic [LA_W-1:0]  ent_start,
  input  logic [LEN_W-1:0] ent_len,
  input  logic [LA_W-1:0]  req_line,
  input  logic [LEN_W-1:0] req_len,
  output logic             overlap,
  output logic             holds,
  output logic [LA_W-1:0]  clip_start,
  output logic [LEN_W-1:0] clip_len,
  output logic [LA_W:0]    ent_end
);
  logic [LA_W:0] es_x, qs_x, qe_x, cs_x, ce_x;

  always_comb begin
    es_x    = {1'b0, ent_start};
    qs_x    = {1'b0, req_line};
    ent_end = es_x + (LA_W+1)'(ent_len);
    qe_x    = qs_x + (LA_W+1)'(req_len);
    overlap = (es_x < qe_x) && (ent_end > qs_x);
    holds   = (qs_x >= es_x) && (qs_x < ent_end);
    cs_x    = (es_x > qs_x) ? es_x : qs_x;
    ce_x    = (ent_end < qe_x) ? ent_end : qe_x;
    clip_start = cs_x[LA_W-1:0];
    clip_len   = LEN_W'(ce_x - cs_x);
  end
endmodule

// File: rtl/poison_range_tracker.sv
module poison_range_tracker
  import poison_tracker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DEPTH  = 256,
  parameter int TS_W   = 32,
  parameter logic [ADDR_W:0] MEM_BYTES = {1'b1, {ADDR_W{1'b0}}},
  localparam int LA_W  = ADDR_W - LINE_SH,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [2:0]        cmd_type,
  input  logic [TS_W-1:0]   time_now,
  output logic              busy,
  output logic              done,
  output logic [1:0]        done_code,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [LEN_W-1:0]  rec_len,
  output logic [CNT_W-1:0]  done_count,
  output logic [7:0]        done_flags,
  output logic [TS_W-1:0]   done_ts
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  trk_state_e state_q, state_d;
  logic [1:0]        op_q, op_d, rc_q, rc_d;
  logic [LA_W-1:0]   line_q, line_d, sv_start_q, sv_start_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [2:0]        type_q, type_d, sv_type_q, sv_type_d;
  logic [IDX_W-1:0]  idx_q, idx_d, hit_q, hit_d;
  logic              found_q, found_d;
  logic [LA_W:0]     sv_end_q, sv_end_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rec_valid_q, rec_valid_d;
  logic [ADDR_W-1:0] rec_addr_q, rec_addr_d;
  logic [LEN_W-1:0]  rec_len_q, rec_len_d;
  logic              ovf_q, ovf_set;
  logic [TS_W-1:0]   ovf_ts_q;

  logic [DEPTH-1:0]  ent_v_q, ent_v_d;
  logic [LA_W-1:0]   ent_s_q [DEPTH];
  logic [LEN_W-1:0]  ent_l_q [DEPTH];
  logic [2:0]        ent_t_q [DEPTH];

  logic              wr_en, kill_en;
  logic [IDX_W-1:0]  kill_idx, free_idx;
  logic [LA_W-1:0]   wr_s;
  logic [LEN_W-1:0]  wr_l;
  logic [2:0]        wr_t;
  logic              tbl_full;

  logic              ev_overlap, ev_holds;
  logic [LA_W-1:0]   ev_cs;
  logic [LEN_W-1:0]  ev_cl;
  logic [LA_W:0]     ev_end;

  poison_slot_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) pick_i (
    .used(ent_v_q), .free_idx(free_idx), .full(tbl_full)
  );

  poison_range_eval #(.LA_W(LA_W), .LEN_W(LEN_W)) eval_i (
    .ent_start(ent_s_q[idx_q]), .ent_len(ent_l_q[idx_q]),
    .req_line(line_q), .req_len(len_q),
    .overlap(ev_overlap), .holds(ev_holds),
    .clip_start(ev_cs), .clip_len(ev_cl), .ent_end(ev_end)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;   op_d = op_q;       rc_d = rc_q;
    line_d = line_q;     len_d = len_q;     type_d = type_q;
    idx_d = idx_q;       hit_d = hit_q;     found_d = found_q;
    sv_start_d = sv_start_q; sv_end_d = sv_end_q; sv_type_d = sv_type_q;
    cnt_d = cnt_q;       rec_valid_d = 1'b0;
    rec_addr_d = rec_addr_q; rec_len_d = rec_len_q;
    wr_en = 1'b0; wr_s = line_q; wr_l = len_q; wr_t = type_q;
    kill_en = 1'b0; kill_idx = hit_q; ovf_set = 1'b0;
    case (state_q)
      ST_IDLE: if (cmd_start) begin
        op_d = cmd_op; line_d = cmd_addr[ADDR_W-1:LINE_SH];
        len_d = cmd_len; type_d = cmd_type;
        idx_d = '0; found_d = 1'b0; cnt_d = '0; rc_d = RC_OK;
        state_d = ST_SCAN;
        case (cmd_op)
          OP_QUERY: if (cmd_addr[LINE_SH-1:0] != '0) begin
            rc_d = RC_BAD_INPUT; state_d = ST_DONE;
          end
          OP_CLEAR: if (({1'b0, cmd_addr} + (ADDR_W+1)'(64)) > MEM_BYTES) begin
            rc_d = RC_BAD_ADDR; state_d = ST_DONE;
          end
          OP_RECORD: begin
            if (cmd_len == '0) begin
              rc_d = RC_BAD_INPUT; state_d = ST_DONE;
            end else begin
              state_d = ST_APPLY;
            end
          end
          default: ;
        endcase
      end
      ST_SCAN: begin
        if (ent_v_q[idx_q] && op_q == OP_QUERY && ev_overlap) begin
          rec_valid_d = 1'b1;
          rec_addr_d  = {ev_cs, 3'b000, ent_t_q[idx_q]};
          rec_len_d   = ev_cl;
          cnt_d       = cnt_q + 1'b1;
        end
        if (ent_v_q[idx_q] && op_q != OP_QUERY && ev_holds && !found_q) begin
          found_d = 1'b1; hit_d = idx_q;
          sv_start_d = ent_s_q[idx_q]; sv_end_d = ev_end; sv_type_d = ent_t_q[idx_q];
        end
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) state_d = ST_APPLY;
      end
      ST_APPLY: begin
        state_d = ST_DONE;
        case (op_q)
          OP_INJECT: if (!found_q) begin
            if (tbl_full) rc_d = RC_FULL;
            else begin
              wr_en = 1'b1; wr_l = LEN_W'(1); wr_t = TYPE_INJECTED;
            end
          end
          OP_RECORD: begin
            if (tbl_full) rc_d = RC_FULL;
            else wr_en = 1'b1;
          end
          OP_CLEAR: if (found_q) begin
            kill_en = 1'b1; state_d = ST_FRAG_LO;
          end
          default: ;
        endcase
      end
      ST_FRAG_LO: begin
        state_d = ST_FRAG_HI;
        if (line_q > sv_start_q) begin
          wr_en = 1'b1; wr_s = sv_start_q;
          wr_l = LEN_W'(line_q - sv_start_q); wr_t = sv_type_q;
        end
      end
      ST_FRAG_HI: begin
        state_d = ST_DONE;
        if (({1'b0, line_q} + 1'b1) < sv_end_q) begin
          if (tbl_full) ovf_set = 1'b1;
          else begin
            wr_en = 1'b1; wr_s = line_q + 1'b1;
            wr_l = LEN_W'(sv_end_q - {1'b0, line_q} - 1'b1); wr_t = sv_type_q;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ent_v_d = ent_v_q;
    if (kill_en) ent_v_d[kill_idx] = 1'b0;
    if (wr_en)   ent_v_d[free_idx] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; op_q <= OP_QUERY; rc_q <= RC_OK;
      line_q <= '0; len_q <= '0; type_q <= '0;
      idx_q <= '0; hit_q <= '0; found_q <= 1'b0;
      sv_start_q <= '0; sv_end_q <= '0; sv_type_q <= '0;
      cnt_q <= '0; rec_valid_q <= 1'b0; rec_addr_q <= '0; rec_len_q <= '0;
      ent_v_q <= '0; ovf_q <= 1'b0;
    end else begin
      state_q <= state_d; op_q <= op_d; rc_q <= rc_d;
      line_q <= line_d; len_q <= len_d; type_q <= type_d;
      idx_q <= idx_d; hit_q <= hit_d; found_q <= found_d;
      sv_start_q <= sv_start_d; sv_end_q <= sv_end_d; sv_type_q <= sv_type_d;
      cnt_q <= cnt_d; rec_valid_q <= rec_valid_d;
      rec_addr_q <= rec_addr_d; rec_len_q <= rec_len_d;
      ent_v_q <= ent_v_d;
      if (ovf_set) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ovf_ts_q <= '0;
    else if (ovf_set && !ovf_q) ovf_ts_q <= time_now;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_s_q[free_idx] <= wr_s;
      ent_l_q[free_idx] <= wr_l;
      ent_t_q[free_idx] <= wr_t;
    end
  end

  logic qry_ok;
  assign qry_ok     = (op_q == OP_QUERY) && (rc_q == RC_OK);
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign done_code  = rc_q;
  assign rec_valid  = rec_valid_q;
  assign rec_addr   = rec_addr_q;
  assign rec_len    = rec_len_q;
  assign done_count = cnt_q;
  assign done_flags = {6'b0, qry_ok && ovf_q, 1'b0};
  assign done_ts    = (qry_ok && ovf_q) ? ovf_ts_q : '0;
endmodule

// File: rtl/poison_range_tracker_chk.sv
module poison_range_tracker_chk #(
  parameter int DEPTH = 256,
  parameter int TS_W  = 32,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             busy,
  input logic             done,
  input logic [1:0]       done_code,
  input logic             rec_valid,
  input logic [CNT_W-1:0] done_count,
  input logic             ovf_q,
  input logic [TS_W-1:0]  ovf_ts_q,
  input logic [DEPTH-1:0] ent_v_q
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start) |=> busy);

  p_idle_table_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_start) |=> $stable(ent_v_q));

  p_rec_in_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (busy && !done));

  p_err_no_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code != 2'd0) |-> (done_count == '0));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  p_ovf_ts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> $stable(ovf_ts_q));
endmodule

bind poison_range_tracker poison_range_tracker_chk #(
  .DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .busy(busy), .done(done),
  .done_code(done_code), .rec_valid(rec_valid), .done_count(done_count),
  .ovf_q(ovf_q), .ovf_ts_q(ovf_ts_q), .ent_v_q(ent_v_q)
);

// File: tb/poison_range_tracker_tb_top.sv
module poison_range_tracker_tb_top;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 6;
  localparam int DEPTH  = 4;
  localparam int TS_W   = 16;
  localparam int CNT_W  = 3;
  localparam int MEMB   = 2048;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, cmd_start;
  logic [1:0]        cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic [2:0]        cmd_type;
  logic [TS_W-1:0]   time_now;
  logic              busy, done, rec_valid;
  logic [1:0]        done_code;
  logic [ADDR_W-1:0] rec_addr;
  logic [LEN_W-1:0]  rec_len;
  logic [CNT_W-1:0]  done_count;
  logic [7:0]        done_flags;
  logic [TS_W-1:0]   done_ts;

  poison_range_tracker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .TS_W(TS_W),
    .MEM_BYTES(13'd2048)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_type(cmd_type),
    .time_now(time_now), .busy(busy), .done(done), .done_code(done_code),
    .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_len(rec_len),
    .done_count(done_count), .done_flags(done_flags), .done_ts(done_ts)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  bit mv[DEPTH];
  int ms[DEPTH], ml[DEPTH], mt[DEPTH];
  bit movf = 0;
  int mts = 0;
  int tnow = 0;

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < DEPTH; i++) if (!mv[i]) return i;
    return -1;
  endfunction

  task automatic put(int s, int l, int t);
    int f = lowest_free();
    mv[f] = 1; ms[f] = s; ml[f] = l; mt[f] = t;
  endtask

  task automatic run_op(int op, int addr, int len, int typ, string req);
    int ea[DEPTH];
    int el[DEPTH];
    int ecnt = 0, erc = 0, got = 0, line, f, h;
    bit qok;
    line = addr / 64;
    tnow = tnow + 3;
    case (op)
      0: if (addr % 64 != 0) erc = 1;
         else for (int i = 0; i < DEPTH; i++) begin
           int es = ms[i], ee = ms[i] + ml[i], qe = line + len, cs, ce;
           if (mv[i] && es < qe && ee > line) begin
             cs = (es > line) ? es : line;
             ce = (ee < qe) ? ee : qe;
             ea[ecnt] = cs * 64 + mt[i]; el[ecnt] = ce - cs; ecnt++;
           end
         end
      1: begin
        h = -1;
        for (int i = 0; i < DEPTH; i++) if (mv[i] && ms[i] <= line && line < ms[i] + ml[i]) h = i;
        if (h < 0) begin
          if (lowest_free() < 0) erc = 3; else put(line, 1, 2);
        end
      end
      2: if (addr + 64 > MEMB) erc = 2;
         else begin
           h = -1;
           for (int i = DEPTH - 1; i >= 0; i--)
             if (mv[i] && ms[i] <= line && line < ms[i] + ml[i]) h = i;
           if (h >= 0) begin
             int es = ms[h], ee = ms[h] + ml[h], t = mt[h];
             mv[h] = 0;
             if (line > es) put(es, line - es, t);
             if (line + 1 < ee) begin
               f = lowest_free();
               if (f < 0) begin
                 if (!movf) begin movf = 1; mts = tnow; end
               end else put(line + 1, ee - line - 1, t);
             end
           end
         end
      default: if (len == 0) erc = 1;
               else if (lowest_free() < 0) erc = 3;
               else put(line, len, typ);
    endcase
    qok = (op == 0) && (erc == 0);
    @(negedge clk);
    time_now = TS_W'(tnow);
    cmd_op = 2'(op); cmd_addr = ADDR_W'(addr); cmd_len = LEN_W'(len);
    cmd_type = 3'(typ); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    forever begin
      if (rec_valid) begin
        if (got < ecnt) begin
          check(req, "rec_addr", int'(rec_addr), ea[got]);
          check(req, "rec_len", int'(rec_len), el[got]);
        end
        got++;
      end
      if (done) break;
      @(negedge clk);
    end
    check(req, "done_code", int'(done_code), erc);
    check(req, "records seen", got, ecnt);
    check(req, "done_count", int'(done_count), ecnt);
    check(req, "flag bit1", int'(done_flags), (qok && movf) ? 2 : 0);
    check(req, "done_ts", int'(done_ts), (qok && movf) ? mts : 0);
    @(negedge clk);
    check("R9", "done pulse ends", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; ms[i] = 0; ml[i] = 0; mt[i] = 0; end
    rst_n = 1'b0; cmd_start = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_len = '0;
    cmd_type = '0; time_now = '0;
    repeat (3) @(negedge clk);
    check("R10", "busy in reset", int'(busy), 0);
    check("R10", "done in reset", int'(done), 0);
    check("R10", "rec_valid in reset", int'(rec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "busy after reset", int'(busy), 0);

    run_op(0, 0, 63, 0, "R10");            // empty table
    run_op(0, 5 * 64 + 4, 8, 0, "R1");      // unaligned query
    run_op(3, 9 * 64, 0, 1, "R4");          // zero length record
    run_op(3, 4 * 64, 6, 5, "R4");          // lines 4..9
    run_op(3, 20 * 64 + 13, 3, 1, "R4");    // lines 20..22

    for (int qs = 0; qs < 25; qs++)
      for (int ql = 1; ql <= 8; ql++)
        run_op(0, qs * 64, ql, 0, "R3");

    run_op(1, 6 * 64 + 9, 0, 0, "R5");      // covered inject
    run_op(0, 0, 63, 0, "R5");
    run_op(1, 30 * 64, 0, 0, "R5");
    run_op(1, 31 * 64, 0, 0, "R5");
    run_op(1, 40 * 64, 0, 0, "R5");         // full
    run_op(3, 41 * 64, 2, 4, "R4");         // full
    run_op(1, 30 * 64 + 1, 0, 0, "R5");     // covered while full
    run_op(0, 0, 63, 0, "R2");

    run_op(2, MEMB - 63, 0, 0, "R6");       // past end
    run_op(2, MEMB - 64, 0, 0, "R6");       // last line, clears line 31
    run_op(2, 12 * 64, 0, 0, "R6");         // no hit
    run_op(0, 0, 63, 0, "R6");

    run_op(2, 6 * 64 + 17, 0, 0, "R7");     // split 4..9 at 6
    run_op(0, 0, 63, 0, "R7");
    run_op(2, 21 * 64, 0, 0, "R8");         // upper fragment dropped
    run_op(0, 0, 63, 0, "R8");
    run_op(2, 8 * 64, 0, 0, "R8");          // second drop, time held
    run_op(0, 0, 63, 0, "R8");

    // start while busy must be ignored
    @(negedge clk);
    cmd_op = 2'd0; cmd_addr = '0; cmd_len = 6'd63; cmd_start = 1'b1;
    @(negedge clk);
    cmd_op = 2'd1; cmd_addr = ADDR_W'(50 * 64);
    check("R9", "busy after start", int'(busy), 1);
    @(negedge clk);
    cmd_start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    run_op(0, 0, 63, 0, "R9");

    for (int l = 0; l < 36; l++) begin
      run_op(2, l * 64, 0, 0, "R7");
      run_op(0, 0, 63, 0, "R7");
      if (l % 4 == 0) run_op(3, (l + 2) * 64, 5, l % 8, "R4");
    end
    for (int qs = 0; qs < 40; qs += 3)
      for (int ql = 1; ql <= 12; ql += 2)
        run_op(0, qs * 64, ql, 0, "R2");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule